// File: doc/BRIEF.md
# Boot-Selectable Aliasing Address Decoder

This block turns a 32-bit bus address into a one-hot select for one of three on-chip memories (main flash, a small system boot memory and SRAM) and gives the local word offset inside the chosen memory. Each memory is decoded at its own natural window using only the high-order address bits. A fourth window at address zero is an alias. It resolves to whichever memory the boot-mode pins chose when reset was released. The processor can therefore fetch its reset vectors from address zero and then jump to the memory's own address range. Reads and writes through the alias reach the same physical word as the same offset in the natural window.

The boot mode is held by a small state machine. `MAP_PENDING` is forced while reset is asserted. On the first clock edge after reset is released, the machine takes one of three transitions: `boot_sel = 2'b00` goes to `MAP_FLASH`, `2'b01` goes to `MAP_SYSMEM`, and `2'b10` or `2'b11` goes to `MAP_SRAM`. Each mapped state loops on itself until the next reset. The decode outputs are combinational from the address, the strobe and this state.

Top module: `boot_alias_decoder`

## Requirements
- R1: With `valid` high, an address in 0x0800_0000..0x0807_FFFF drives `mem_sel = 3'b001` (flash) and `local_addr = addr[18:0]`.
- R2: With `valid` high, an address in 0x1FFF_F000..0x1FFF_FFFF drives `mem_sel = 3'b010` (system memory) and `local_addr = {7'b0, addr[11:0]}`.
- R3: With `valid` high, an address in 0x2000_0000..0x2000_FFFF drives `mem_sel = 3'b100` (SRAM) and `local_addr = {3'b0, addr[15:0]}`.
- R4: `boot_sel` is captured on the first rising clock edge after `rst_n` rises. Afterwards an address in 0x0000_0000..0x0007_FFFF selects the captured target (00 gives flash, 01 gives system memory, 1x gives SRAM) with the same `local_addr` as the equal offset in that target's natural window. For example, address 0x4 gives the same result as address 0x0800_0004 when flash is captured.
- R5: An alias access whose offset lies beyond the captured target's size raises `dec_err` and selects nothing. The limits are offset 0x1000 and above for system memory, and 0x1_0000 and above for SRAM.
- R6: Changes on `boot_sel` after the capture edge leave the alias mapping unchanged until the next reset.
- R7: While reset is held, and in the cycle between reset release and the capture edge, an alias access raises `dec_err` and selects nothing.
- R8: With `valid` high, an address in no window raises `dec_err`, drives `mem_sel = 0` and drives `local_addr = 0`.
- R9: With `valid` low, `mem_sel`, `dec_err` and `mem_wr` are all 0.
- R10: `mem_wr` equals `valid & wr` whenever a memory is selected, and is 0 otherwise. Writes through the alias and through the natural window therefore give identical select, offset and write strobe.
- R11: With `valid` high, exactly one of the three `mem_sel` bits and `dec_err` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the boot-mode capture |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_sel | input | 2 | Boot-mode pins, captured once after reset |
| valid | input | 1 | Access strobe, one cycle per access |
| wr | input | 1 | 1 for a write, 0 for a read |
| addr | input | 32 | Bus address |
| mem_sel | output | 3 | One-hot select: bit 0 flash, bit 1 system memory, bit 2 SRAM |
| local_addr | output | 19 | Offset inside the selected memory |
| mem_wr | output | 1 | Write strobe towards the selected memory |
| dec_err | output | 1 | Access hit no usable window |

## Verification
The hardest state to reach is the single pending cycle between reset release and the capture edge. The bench releases `rst_n` just after a falling edge and probes an alias address before the next rising edge, expecting a decode error. It then probes again after that edge and expects the mapped target. Pin changes after capture are only meaningful if the alias is probed again afterwards. For that reason each boot-mode scenario flips `boot_sel` straight after capture and then repeats the alias accesses. The three alias targets need separate resets, so every boot mode gets its own scenario.

// File: rtl/boot_alias_pkg.sv
package boot_alias_pkg;

    typedef enum logic [1:0] {
        MAP_PENDING = 2'd0,
        MAP_FLASH   = 2'd1,
        MAP_SYSMEM  = 2'd2,
        MAP_SRAM    = 2'd3
    } map_state_e;

    localparam int TGT_N = 3;

    localparam logic [TGT_N-1:0] SEL_NONE   = 3'b000;
    localparam logic [TGT_N-1:0] SEL_FLASH  = 3'b001;
    localparam logic [TGT_N-1:0] SEL_SYSMEM = 3'b010;
    localparam logic [TGT_N-1:0] SEL_SRAM   = 3'b100;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/region_match.sv
module region_match #(
    parameter int          ADDR_W = 32,
    parameter int          WIN_AW = 19,
    parameter logic [31:0] BASE   = 32'h0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [WIN_AW-1:0] offset
);
    localparam int TAG_W = ADDR_W - WIN_AW;
    localparam logic [TAG_W-1:0] TAG = BASE[ADDR_W-1:WIN_AW];

    // High-order tag compare only; low bits pass through as the offset.
    always_comb begin
        hit    = (addr[ADDR_W-1:WIN_AW] == TAG);
        offset = addr[WIN_AW-1:0];
    end

endmodule

// File: rtl/boot_mode_fsm.sv
module boot_mode_fsm
    import boot_alias_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] boot_sel,
    output map_state_e map_state
);
    map_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MAP_PENDING;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MAP_PENDING: begin
                unique casez (boot_sel)
                    2'b00:   state_d = MAP_FLASH;
                    2'b01:   state_d = MAP_SYSMEM;
                    2'b1?:   state_d = MAP_SRAM;
                    default: state_d = MAP_FLASH;
                endcase
            end
            MAP_FLASH:  state_d = MAP_FLASH;
            MAP_SYSMEM: state_d = MAP_SYSMEM;
            MAP_SRAM:   state_d = MAP_SRAM;
            default:    state_d = MAP_PENDING;
        endcase
    end

    assign map_state = state_q;

    // R4: the pending state lasts exactly one edge after reset release
    assert_pending_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MAP_PENDING) |=> (state_q != MAP_PENDING));

    // R6: once mapped, the mapping never moves until reset
    assert_map_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != MAP_PENDING) |=> (state_q == $past(state_q)));

endmodule

// File: rtl/boot_alias_decoder.sv
module boot_alias_decoder
    import boot_alias_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          FLASH_AW   = 19,
    parameter int          SYS_AW     = 12,
    parameter int          SRAM_AW    = 16,
    parameter int          ALIAS_AW   = 19,
    parameter logic [31:0] FLASH_BASE = 32'h0800_0000,
    parameter logic [31:0] SYS_BASE   = 32'h1FFF_F000,
    parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
    parameter logic [31:0] ALIAS_BASE = 32'h0000_0000,
    parameter int          LOC_W      = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        boot_sel,
    input  logic              valid,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic [TGT_N-1:0]  mem_sel,
    output logic [LOC_W-1:0]  local_addr,
    output logic              mem_wr,
    output logic              dec_err
);
    localparam int WIDEST = max2(max2(FLASH_AW, SYS_AW), max2(SRAM_AW, ALIAS_AW));

    initial begin
        if (LOC_W < WIDEST) $error("LOC_W narrower than widest window");
    end

    map_state_e            map_state;
    logic                  hit_f, hit_s, hit_r, hit_a;
    logic [FLASH_AW-1:0]   off_f;
    logic [SYS_AW-1:0]     off_s;
    logic [SRAM_AW-1:0]    off_r;
    logic [ALIAS_AW-1:0]   off_a;
    logic                  a_fits_sys, a_fits_sram, a_fits_flash;

    boot_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_sel  (boot_sel),
        .map_state (map_state)
    );

    region_match #(.ADDR_W(ADDR_W), .WIN_AW(FLASH_AW), .BASE(FLASH_BASE)) u_flash (
        .addr(addr), .hit(hit_f), .offset(off_f));
    region_match #(.ADDR_W(ADDR_W), .WIN_AW(SYS_AW), .BASE(SYS_BASE)) u_sys (
        .addr(addr), .hit(hit_s), .offset(off_s));
    region_match #(.ADDR_W(ADDR_W), .WIN_AW(SRAM_AW), .BASE(SRAM_BASE)) u_sram (
        .addr(addr), .hit(hit_r), .offset(off_r));
    region_match #(.ADDR_W(ADDR_W), .WIN_AW(ALIAS_AW), .BASE(ALIAS_BASE)) u_alias (
        .addr(addr), .hit(hit_a), .offset(off_a));

    // Alias offset must fall inside the target memory's own window.
    always_comb begin
        a_fits_flash = ((off_a >> FLASH_AW) == '0);
        a_fits_sys   = ((off_a >> SYS_AW)   == '0);
        a_fits_sram  = ((off_a >> SRAM_AW)  == '0);
    end

    // Output process: select, offset and error from address and mode.
    always_comb begin
        mem_sel    = SEL_NONE;
        local_addr = '0;
        dec_err    = 1'b0;
        if (valid) begin
            if (hit_f) begin
                mem_sel    = SEL_FLASH;
                local_addr = LOC_W'(off_f);
            end else if (hit_s) begin
                mem_sel    = SEL_SYSMEM;
                local_addr = LOC_W'(off_s);
            end else if (hit_r) begin
                mem_sel    = SEL_SRAM;
                local_addr = LOC_W'(off_r);
            end else if (hit_a) begin
                unique case (map_state)
                    MAP_FLASH: begin
                        if (a_fits_flash) begin
                            mem_sel    = SEL_FLASH;
                            local_addr = LOC_W'(off_a);
                        end else begin
                            dec_err = 1'b1;
                        end
                    end
                    MAP_SYSMEM: begin
                        if (a_fits_sys) begin
                            mem_sel    = SEL_SYSMEM;
                            local_addr = LOC_W'(off_a);
                        end else begin
                            dec_err = 1'b1;
                        end
                    end
                    MAP_SRAM: begin
                        if (a_fits_sram) begin
                            mem_sel    = SEL_SRAM;
                            local_addr = LOC_W'(off_a);
                        end else begin
                            dec_err = 1'b1;
                        end
                    end
                    default: dec_err = 1'b1;
                endcase
            end else begin
                dec_err = 1'b1;
            end
        end
        mem_wr = wr && (mem_sel != SEL_NONE);
    end

    // R11: exactly one of select bits and error per valid access
    assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ($countones({mem_sel, dec_err}) == 1));

    // R9: idle bus drives nothing
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (mem_sel == SEL_NONE && !dec_err && !mem_wr));

    // R7: alias unusable before capture
    assert_alias_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && map_state == MAP_PENDING && hit_a) |-> (dec_err && mem_sel == SEL_NONE));

    // R10: write strobe only with a selected memory and a write access
    assert_wr_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (wr && valid && $onehot0(mem_sel) && mem_sel != SEL_NONE));

endmodule

// File: tb/boot_alias_decoder_tb.sv
`timescale 1ns/1ps
module boot_alias_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  boot_sel = 2'b00;
    logic        valid = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] addr = '0;
    logic [2:0]  mem_sel;
    logic [18:0] local_addr;
    logic        mem_wr;
    logic        dec_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    boot_alias_decoder u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_sel   (boot_sel),
        .valid      (valid),
        .wr         (wr),
        .addr       (addr),
        .mem_sel    (mem_sel),
        .local_addr (local_addr),
        .mem_wr     (mem_wr),
        .dec_err    (dec_err)
    );

    // Drive at falling edge, sample 1 ns later (away from rising edge).
    task automatic access(input string req, input logic [31:0] a, input logic w,
                          input logic v, input logic [2:0] esel,
                          input logic [18:0] eloc, input logic eerr);
        logic ewr;
        @(negedge clk);
        addr = a; wr = w; valid = v;
        #1;
        ewr = v && w && (esel != 3'b000);
        checks++;
        if (mem_sel !== esel || local_addr !== eloc || dec_err !== eerr || mem_wr !== ewr) begin
            errors++;
            $display("FAIL %s addr=%h: sel=%b loc=%h err=%b wr=%b expected sel=%b loc=%h err=%b wr=%b",
                     req, a, mem_sel, local_addr, dec_err, mem_wr, esel, eloc, eerr, ewr);
        end
        if (v) begin
            checks++;
            if ($countones({mem_sel, dec_err}) != 1) begin
                errors++;
                $display("FAIL R11 addr=%h: outcome bits=%b expected exactly one set",
                         a, {mem_sel, dec_err});
            end
        end
    endtask

    // Reset with given pins; probes the pending cycle (R7).
    task automatic reset_with(input logic [1:0] bs);
        @(negedge clk);
        rst_n = 1'b0; boot_sel = bs; valid = 1'b1; addr = 32'h0000_0004; wr = 1'b0;
        #1;
        checks++;
        if (dec_err !== 1'b1 || mem_sel !== 3'b000) begin
            errors++;
            $display("FAIL R7 in reset: sel=%b err=%b expected sel=000 err=1", mem_sel, dec_err);
        end
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (dec_err !== 1'b1 || mem_sel !== 3'b000) begin
            errors++;
            $display("FAIL R7 pending cycle: sel=%b err=%b expected sel=000 err=1", mem_sel, dec_err);
        end
    endtask

    task automatic t_natural();
        access("R1", 32'h0800_0000, 1'b0, 1'b1, 3'b001, 19'h0_0000, 1'b0);
        access("R1", 32'h0807_FFFC, 1'b1, 1'b1, 3'b001, 19'h7_FFFC, 1'b0);
        access("R2", 32'h1FFF_F000, 1'b0, 1'b1, 3'b010, 19'h0_0000, 1'b0);
        access("R2", 32'h1FFF_FFFF, 1'b1, 1'b1, 3'b010, 19'h0_0FFF, 1'b0);
        access("R3", 32'h2000_0000, 1'b1, 1'b1, 3'b100, 19'h0_0000, 1'b0);
        access("R3", 32'h2000_FFF0, 1'b0, 1'b1, 3'b100, 19'h0_FFF0, 1'b0);
    endtask

    task automatic t_unmapped();
        access("R8", 32'h0808_0000, 1'b0, 1'b1, 3'b000, 19'h0, 1'b1);
        access("R8", 32'h07FF_FFFC, 1'b1, 1'b1, 3'b000, 19'h0, 1'b1);
        access("R8", 32'h1FFF_EFFC, 1'b0, 1'b1, 3'b000, 19'h0, 1'b1);
        access("R8", 32'h2001_0000, 1'b1, 1'b1, 3'b000, 19'h0, 1'b1);
        access("R8", 32'h4000_0000, 1'b0, 1'b1, 3'b000, 19'h0, 1'b1);
        access("R8", 32'h0008_0000, 1'b0, 1'b1, 3'b000, 19'h0, 1'b1);
    endtask

    task automatic t_idle();
        access("R9", 32'h0800_0010, 1'b1, 1'b0, 3'b000, 19'h0, 1'b0);
        access("R9", 32'h4000_0000, 1'b1, 1'b0, 3'b000, 19'h0, 1'b0);
        access("R9", 32'h0000_0000, 1'b0, 1'b0, 3'b000, 19'h0, 1'b0);
    endtask

    task automatic t_boot_flash();
        reset_with(2'b00);
        @(negedge clk);
        boot_sel = 2'b01;   // R6: late pin change must be ignored
        access("R4", 32'h0000_0000, 1'b0, 1'b1, 3'b001, 19'h0_0000, 1'b0);
        access("R4", 32'h0000_0004, 1'b0, 1'b1, 3'b001, 19'h0_0004, 1'b0);
        access("R4", 32'h0800_0004, 1'b0, 1'b1, 3'b001, 19'h0_0004, 1'b0);
        access("R10", 32'h0000_1234, 1'b1, 1'b1, 3'b001, 19'h0_1234, 1'b0);
        access("R10", 32'h0800_1234, 1'b1, 1'b1, 3'b001, 19'h0_1234, 1'b0);
        access("R4", 32'h0007_FFFC, 1'b0, 1'b1, 3'b001, 19'h7_FFFC, 1'b0);
        boot_sel = 2'b11;
        repeat (3) @(negedge clk);
        access("R6", 32'h0000_0008, 1'b0, 1'b1, 3'b001, 19'h0_0008, 1'b0);
    endtask

    task automatic t_boot_sys();
        reset_with(2'b01);
        @(negedge clk);
        boot_sel = 2'b00;
        access("R4", 32'h0000_0004, 1'b0, 1'b1, 3'b010, 19'h0_0004, 1'b0);
        access("R4", 32'h0000_0FFF, 1'b0, 1'b1, 3'b010, 19'h0_0FFF, 1'b0);
        access("R5", 32'h0000_1000, 1'b0, 1'b1, 3'b000, 19'h0, 1'b1);
        access("R5", 32'h0004_0000, 1'b1, 1'b1, 3'b000, 19'h0, 1'b1);
        access("R10", 32'h0000_0020, 1'b1, 1'b1, 3'b010, 19'h0_0020, 1'b0);
        access("R1", 32'h0800_0004, 1'b0, 1'b1, 3'b001, 19'h0_0004, 1'b0);
        boot_sel = 2'b10;
        repeat (2) @(negedge clk);
        access("R6", 32'h0000_0004, 1'b0, 1'b1, 3'b010, 19'h0_0004, 1'b0);
    endtask

    task automatic t_boot_sram(input logic [1:0] bs);
        reset_with(bs);
        @(negedge clk);
        boot_sel = 2'b00;
        access("R4", 32'h0000_0004, 1'b0, 1'b1, 3'b100, 19'h0_0004, 1'b0);
        access("R4", 32'h0000_FFFC, 1'b1, 1'b1, 3'b100, 19'h0_FFFC, 1'b0);
        access("R5", 32'h0001_0000, 1'b0, 1'b1, 3'b000, 19'h0, 1'b1);
        access("R10", 32'h2000_0040, 1'b1, 1'b1, 3'b100, 19'h0_0040, 1'b0);
        access("R10", 32'h0000_0040, 1'b1, 1'b1, 3'b100, 19'h0_0040, 1'b0);
        boot_sel = 2'b01;
        repeat (2) @(negedge clk);
        access("R6", 32'h0000_0000, 1'b0, 1'b1, 3'b100, 19'h0_0000, 1'b0);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        reset_with(2'b00);
        @(negedge clk);
        t_natural();
        t_unmapped();
        t_idle();
        t_boot_flash();
        t_boot_sys();
        t_boot_sram(2'b10);
        t_boot_sram(2'b11);
        t_natural();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule